// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block protects a shared medium from a station that keeps transmitting. It measures each unbroken stretch of transmit activity in ticks of a free-running timebase (nominally 10 MHz). When a stretch reaches the jabber limit, it drops the driver enable and requests a collision signal toward the host. A sensed driver fault has the same effect at once. Release comes only after a long penalty period. That period counts only ticks on which the transmit input is idle and no fault is sensed, and it restarts from zero whenever either one reappears.

The block also handles two other causes of shutdown. An external-disable input stands for a removed driver supply: it blocks the driver and forces the collision request for as long as it is asserted. A supply-good input blocks the driver while the supply is low. All inputs are synchronous digital levels. Both limits are parameters. The defaults are 260,000 ticks (26 ms) and 4,000,000 ticks (400 ms).

Top module: `jabber_watchdog`

## Requirements
- R1: After a synchronous reset, and from the cycle after any reset, the block is in the watching state. With supply good and no external disable, `drv_en` is 1 and `col_req` is 0.
- R2: When `tx_active` is 1 on `JAB_TICKS` consecutive tick cycles, the block trips. From the following clock cycle, `drv_en` is 0 and `col_req` is 1.
- R3: The jabber count clears on any cycle where `tx_active` is 0. A stretch of `JAB_TICKS-1` active ticks, one idle cycle, and then `JAB_TICKS-1` more active ticks does not trip.
- R4: Cycles with `tick` at 0 neither advance nor clear either count.
- R5: Once tripped, the block returns to watching on the clock after the `UNJAB_TICKS`-th consecutive tick cycle that has `tx_active` 0 and `drv_fault` 0. Until then, `drv_en` stays 0 and `col_req` stays 1.
- R6: If `tx_active` is 1 on any cycle during the penalty wait, the penalty count restarts from zero.
- R7: A `drv_fault` of 1 trips the block on the next clock, whatever the jabber count. A fault during the penalty wait restarts that count.
- R8: While `ext_disable` is 1, `drv_en` is 0 and `col_req` is 1 in the same cycle. It does not stop or restart the penalty count.
- R9: While `supply_ok` is 0, `drv_en` is 0. Supply loss alone does not raise `col_req`.
- R10: Whenever the driver is inhibited with supply good, `col_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable, one cycle per oscillator period |
| tx_active | input | 1 | Transmit activity from the host |
| drv_fault | input | 1 | Sensed fault on the line driver |
| ext_disable | input | 1 | Driver supply removed externally |
| supply_ok | input | 1 | Supply above minimum operating level |
| drv_en | output | 1 | Line driver enable |
| col_req | output | 1 | Request for collision signalling to the host |

## Verification
The bench tests both limits from each side: one active tick short of the jabber limit, and one quiet tick short of release. A design off by one in either counter would trip or release a cycle early or late. It breaks a transmit stretch with a single idle cycle, and interrupts the penalty wait with both renewed activity and a fault. A design that failed to clear the counts would trip or release too soon. It also inserts tick-free cycles, so a design that counted clock cycles instead of ticks would trip early. Finally, it checks that supply loss, external disable and reset each act as required, and that none of them disturbs behaviour it should leave alone.

// File: rtl/jw_pkg.sv
package jw_pkg;

    typedef enum logic [0:0] {
        JW_WATCH = 1'b0,
        JW_HOLD  = 1'b1
    } jw_state_e;

    typedef struct packed {
        logic tick;
        logic tx;
        logic fault;
    } jw_obs_t;

    function automatic int jw_width(input int span);
        return (span <= 2) ? 1 : $clog2(span);
    endfunction

    function automatic logic jw_quiet(input jw_obs_t o);
        return !o.tx && !o.fault;
    endfunction

endpackage

// File: rtl/jw_span_counter.sv
module jw_span_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    import jw_pkg::*;

    localparam int W = jw_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign hit = inc && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // R4: a cycle without increment or clear leaves the count unchanged
    a_r4_hold_without_inc: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(cnt));

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/jw_fsm.sv
module jw_fsm (
    input  logic              clk,
    input  logic              rst,
    input  jw_pkg::jw_obs_t   obs,
    input  logic              run_hit,
    input  logic              quiet_hit,
    output jw_pkg::jw_state_e state
);
    import jw_pkg::*;

    jw_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            JW_WATCH: if (run_hit || obs.fault) nxt = JW_HOLD;
            JW_HOLD:  if (quiet_hit)            nxt = JW_WATCH;
            default:                            nxt = JW_WATCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= JW_WATCH;
        else     state <= nxt;
    end

    // R7: a fault seen while watching lands in the hold state
    a_r7_fault_trips: assert property (@(posedge clk) disable iff (rst)
        (state == JW_WATCH && obs.fault) |=> state == JW_HOLD);

    // R5: leaving hold needs a quiet tick in the cycle before
    a_r5_release_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == JW_WATCH && $past(state == JW_HOLD) && !$past(rst))
            |-> $past(obs.tick && jw_quiet(obs)));

endmodule

// File: rtl/jabber_watchdog.sv
module jabber_watchdog #(
    parameter int JAB_TICKS   = 260000,
    parameter int UNJAB_TICKS = 4000000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic tx_active,
    input  logic drv_fault,
    input  logic ext_disable,
    input  logic supply_ok,
    output logic drv_en,
    output logic col_req
);
    import jw_pkg::*;

    jw_obs_t   obs;
    jw_state_e state;
    logic      watching, jabbed;
    logic      run_hit, quiet_hit;

    assign obs      = '{tick: tick, tx: tx_active, fault: drv_fault};
    assign watching = (state == JW_WATCH);
    assign jabbed   = (state == JW_HOLD);

    jw_span_counter #(.LIMIT(JAB_TICKS)) u_run (
        .clk (clk),
        .rst (rst),
        .clr (!watching || !obs.tx),
        .inc (watching && obs.tx && obs.tick),
        .hit (run_hit)
    );

    jw_span_counter #(.LIMIT(UNJAB_TICKS)) u_quiet (
        .clk (clk),
        .rst (rst),
        .clr (!jabbed || !jw_quiet(obs)),
        .inc (jabbed && jw_quiet(obs) && obs.tick),
        .hit (quiet_hit)
    );

    jw_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .obs       (obs),
        .run_hit   (run_hit),
        .quiet_hit (quiet_hit),
        .state     (state)
    );

    assign drv_en  = watching && supply_ok && !ext_disable;
    assign col_req = jabbed || ext_disable;

    a_r8_ext_forces: assert property (@(posedge clk) disable iff (rst)
        ext_disable |-> (col_req && !drv_en));

    a_r9_supply_blocks: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> !drv_en);

    a_r10_col_when_inhibited: assert property (@(posedge clk) disable iff (rst)
        (!drv_en && supply_ok) |-> col_req);

    // R2: entering hold requires a fault or an active tick just before
    a_r2_trip_cause: assert property (@(posedge clk) disable iff (rst)
        ($rose(jabbed) && !$past(rst)) |-> $past(drv_fault || (tx_active && tick)));

endmodule

// File: tb/jabber_watchdog_tb.sv
module jabber_watchdog_tb;

    localparam int JAB   = 4;
    localparam int UNJAB = 6;
    localparam int NV    = 31;
    // bits: [6]tx [5]fault [4]ext [3]supply_ok [2]tick | [1]exp drv_en [0]exp col_req
    localparam logic [6:0] VEC [0:NV-1] = '{
        7'b1001110, 7'b1001110, 7'b1001110, 7'b0001110,   // R3 break before limit
        7'b1001110, 7'b1001110, 7'b1001110, 7'b1001010,   // R4 tick-free cycle
        7'b1001101, 7'b1001101,                           // R2 trip on 4th tick
        7'b0001101, 7'b0001101, 7'b0001101, 7'b0001101, 7'b0001101,
        7'b1001101,                                       // R6 restart penalty
        7'b0001101, 7'b0001101, 7'b0001101, 7'b0001101, 7'b0001101,
        7'b0001110,                                       // R5 release on 6th quiet tick
        7'b0011101,                                       // R8 external disable
        7'b0000100,                                       // R9 supply low, no col_req
        7'b0101101,                                       // R7 fault trips
        7'b0001101, 7'b0001101, 7'b0001101, 7'b0001101, 7'b0001101,
        7'b0001110                                        // R5 release after fault
    };

    logic clk = 1'b0;
    logic rst, tick, tx_active, drv_fault, ext_disable, supply_ok;
    logic drv_en, col_req;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #2 clk = ~clk;

    jabber_watchdog #(.JAB_TICKS(JAB), .UNJAB_TICKS(UNJAB)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .tx_active(tx_active),
        .drv_fault(drv_fault), .ext_disable(ext_disable), .supply_ok(supply_ok),
        .drv_en(drv_en), .col_req(col_req)
    );

    task automatic step(input logic r, input logic tx, input logic fl,
                        input logic ex, input logic sok, input logic tk);
        @(negedge clk);
        rst = r; tx_active = tx; drv_fault = fl; ext_disable = ex;
        supply_ok = sok; tick = tk;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic ed, input logic ec);
        n_chk++;
        if (drv_en !== ed || col_req !== ec) begin
            n_bad++;
            $display("FAIL %s: drv_en=%b col_req=%b expected drv_en=%b col_req=%b",
                     req, drv_en, col_req, ed, ec);
        end
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: expired expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R1 reset state", 1'b1, 1'b0);

        for (int v = 0; v < NV; v++) begin
            step(1'b0, VEC[v][6], VEC[v][5], VEC[v][4], VEC[v][3], VEC[v][2]);
            check($sformatf("R2-table vector %0d", v), VEC[v][1], VEC[v][0]);
        end

        // R7: fault in the penalty wait restarts the count
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R7 fault trip", 1'b0, 1'b1);
        quiet(3);
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        quiet(5);
        check("R7 fault restarted penalty", 1'b0, 1'b1);
        quiet(1);
        check("R7 release after full quiet", 1'b1, 1'b0);

        // R8: external disable does not halt the penalty count
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < UNJAB; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R8 ext forces col_req", 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R8 penalty ran under ext", 1'b1, 1'b0);

        // R1: reset while jabbed restores the driver
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R10 jabbed inhibits with col_req", 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R1 reset from jabbed", 1'b1, 1'b0);

        // R2: exactly JAB active ticks trip, not fewer
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R2 no trip at limit-1", 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R2 trip at limit", 1'b0, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule